// File: doc/BRIEF.md
# Single-Bit Flag-Steered Division Step Unit

This block provides the arithmetic core behind software-sequenced division in a 32-bit processor. It holds three one-bit flags (Q, M and T) and, on command, performs one of three operations: a setup for unsigned division that clears the flags, a setup for signed division that seeds the flags from the operand signs, or one non-restoring division step. Each step yields one quotient bit.

During a step the dividend is shifted left by one position with the current T flag entering at bit 0. The divisor is then added to or subtracted from the shifted value. The choice between adding and subtracting comes from the Q and M flags. The carry or borrow of that operation updates Q, and T then reports whether the new Q agrees with M. A surrounding sequencer or instruction stream repeats the step and collects the quotient bits from T. That sequencing lies outside this block. Every operation takes one clock edge, and the flags and the result register are updated together.

Top module: `div_step_unit`

## Requirements
- R1: During and after reset, before any operation, the Q, M and T flags are 0 and the result output is 0.
- R2: Operation code 2'b00 (idle) leaves the flags and the result output unchanged.
- R3: Operation code 2'b01 (unsigned setup) clears Q, M and T to 0 and leaves the result output unchanged.
- R4: Operation code 2'b10 (signed setup) loads Q from bit WIDTH-1 of the dividend and M from bit WIDTH-1 of the divisor, and sets T to Q xor M. The result output is left unchanged.
- R5: Operation code 2'b11 (step) subtracts the divisor when the Q and M flags held before the step are equal, and adds it when they differ.
- R6: A step forms its working value as the dividend shifted left by one, with the T flag held before the step in bit 0. The add or subtract result becomes the new result output.
- R7: A step sets Q to (dividend bit WIDTH-1) xor M xor c. Here c is the borrow of a subtraction (the result is unsigned-greater than the working value) or the carry of an addition (the result is unsigned-less than the working value). M is not changed by a step.
- R8: After a step, T is 1 when the new Q equals M, and 0 otherwise.
- R9: A zero divisor is not trapped. The step proceeds by the same rules, so the result equals the working value and no carry or borrow arises.
- R10: Each operation commits on the first rising clock edge at which it is presented. Its effect is visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opSel | input | 2 | Operation: 00 idle, 01 unsigned setup, 10 signed setup, 11 step |
| dividendIn | input | WIDTH | Current partial remainder / dividend |
| divisorIn | input | WIDTH | Divisor |
| remOut | output | WIDTH | Registered result of the last step |
| qFlag | output | 1 | Q flag |
| mFlag | output | 1 | M flag |
| tFlag | output | 1 | T flag |

## Verification
The bench builds the unit with its default WIDTH of 32. At that width the carry and borrow out of the top bit show up at realistic operand values such as 0xFFFFFFFE plus 3, and the sign bits that seed the signed setup are at bit 31. Hand-worked steps cover subtract-with-borrow, add-with-carry and zero-divisor cases. A long pseudo-random mix of setups, steps and idle cycles is checked against a model that derives carry and borrow by comparison and not from an extended adder. This reaches every combination of Q, M and T at entry to a step.

// File: rtl/div_step_pkg.sv
package div_step_pkg;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'b00,
    OP_USETUP = 2'b01,
    OP_SSETUP = 2'b10,
    OP_STEP   = 2'b11
  } divOp_e;

  typedef struct packed {
    logic clrFlags;
    logic seedSigned;
    logic doStep;
  } divStrobe_t;

endpackage

// File: rtl/div_step_ctrl.sv
module div_step_ctrl
  import div_step_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] opSel,
  output divStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    unique case (divOp_e'(opSel))
      OP_USETUP: strobe.clrFlags   = 1'b1;
      OP_SSETUP: strobe.seedSigned = 1'b1;
      OP_STEP:   strobe.doStep     = 1'b1;
      default:   strobe            = '0;
    endcase
  end

  // at most one strobe per cycle (R2, R3, R4, R5)
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clrFlags, strobe.seedSigned, strobe.doStep}));

endmodule

// File: rtl/div_step_datapath.sv
module div_step_datapath
  import div_step_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strobe,
  input  logic [WIDTH-1:0] dividendIn,
  input  logic [WIDTH-1:0] divisorIn,
  output logic [WIDTH-1:0] remOut,
  output logic             qFlag,
  output logic             mFlag,
  output logic             tFlag
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] remReg;
  logic             qReg, mReg, tReg;

  logic [WIDTH-1:0] shifted;
  logic             subMode;
  logic [WIDTH:0]   sumExt;
  logic             carryBorrow;
  logic             stepQ;
  logic             stepT;

  // working value and add/subtract selection
  always_comb begin
    shifted = {dividendIn[MSB-1:0], tReg};
    subMode = (qReg == mReg);
    if (subMode) sumExt = {1'b0, shifted} - {1'b0, divisorIn};
    else         sumExt = {1'b0, shifted} + {1'b0, divisorIn};
    carryBorrow = sumExt[WIDTH];
    stepQ = dividendIn[MSB] ^ mReg ^ carryBorrow;
    stepT = (stepQ == mReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg <= '0;
      qReg   <= 1'b0;
      mReg   <= 1'b0;
      tReg   <= 1'b0;
    end else if (strobe.clrFlags) begin
      qReg <= 1'b0;
      mReg <= 1'b0;
      tReg <= 1'b0;
    end else if (strobe.seedSigned) begin
      qReg <= dividendIn[MSB];
      mReg <= divisorIn[MSB];
      tReg <= dividendIn[MSB] ^ divisorIn[MSB];
    end else if (strobe.doStep) begin
      remReg <= sumExt[WIDTH-1:0];
      qReg   <= stepQ;
      tReg   <= stepT;
    end
  end

  assign remOut = remReg;
  assign qFlag  = qReg;
  assign mFlag  = mReg;
  assign tFlag  = tReg;

  // idle keeps all state
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> ($stable(remReg) && $stable({qReg, mReg, tReg})));

  // unsigned setup clears flags, result kept
  p_uclear_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrFlags |=> (!qReg && !mReg && !tReg && $stable(remReg)));

  // signed setup: T agrees with the seeded Q and M
  p_sseed_t_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.seedSigned |=> ((tReg == (qReg ^ mReg)) && $stable(remReg)));

  // step keeps M, T tracks new Q against M
  p_step_m_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doStep |=> $stable(mReg));

  p_step_t_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doStep |=> (tReg == (qReg == mReg)));

endmodule

// File: rtl/div_step_unit.sv
module div_step_unit
  import div_step_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] dividendIn,
  input  logic [WIDTH-1:0] divisorIn,
  output logic [WIDTH-1:0] remOut,
  output logic             qFlag,
  output logic             mFlag,
  output logic             tFlag
);

  divStrobe_t strobe;

  div_step_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opSel  (opSel),
    .strobe (strobe)
  );

  div_step_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .dividendIn (dividendIn),
    .divisorIn  (divisorIn),
    .remOut     (remOut),
    .qFlag      (qFlag),
    .mFlag      (mFlag),
    .tFlag      (tFlag)
  );

endmodule

// File: tb/div_step_unit_tb.sv
module div_step_unit_tb;

  localparam int W = 32;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   opSel = 2'b00;
  logic [W-1:0] dividendIn = '0;
  logic [W-1:0] divisorIn = '0;
  logic [W-1:0] remOut;
  logic         qFlag, mFlag, tFlag;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench-side model state
  logic [W-1:0] mRem;
  logic mQ, mM, mT;

  always #(CLK_PERIOD/2) clk = ~clk;

  div_step_unit #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .opSel(opSel),
    .dividendIn(dividendIn), .divisorIn(divisorIn),
    .remOut(remOut), .qFlag(qFlag), .mFlag(mFlag), .tFlag(tFlag)
  );

  task automatic check(input string req, input logic [W+2:0] got, input logic [W+2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got q/m/t/rem=%h expected %h", req, got, exp);
    end
  endtask

  // model from the requirements; carry/borrow by comparison
  task automatic modelOp(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] sh, res;
    logic cb, oldQ;
    case (op)
      2'b01: begin mQ = 0; mM = 0; mT = 0; end
      2'b10: begin mQ = a[W-1]; mM = b[W-1]; mT = mQ ^ mM; end
      2'b11: begin
        oldQ = mQ;
        sh = {a[W-2:0], mT};
        if (oldQ == mM) begin res = sh - b; cb = (res > sh); end
        else            begin res = sh + b; cb = (res < sh); end
        mQ = a[W-1] ^ mM ^ cb;
        mT = (mQ == mM);
        mRem = res;
      end
      default: ;
    endcase
  endtask

  // present op at negedge, it commits at next posedge, sample at following negedge
  task automatic doOp(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    opSel = op; dividendIn = a; divisorIn = b;
    @(posedge clk);
    @(negedge clk);
    opSel = 2'b00;
    modelOp(op, a, b);
  endtask

  function automatic logic [W+2:0] outs();
    return {qFlag, mFlag, tFlag, remOut};
  endfunction

  function automatic logic [W+2:0] exps();
    return {mQ, mM, mT, mRem};
  endfunction

  task automatic tReset();
    mRem = '0; mQ = 0; mM = 0; mT = 0;
    check("R1 during reset", outs(), exps());
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", outs(), exps());
  endtask

  task automatic tHand();
    doOp(2'b01, '0, '0);
    check("R3 clear", outs(), {3'b000, 32'h0});
    // subtract, no borrow: 0xA - 3 = 7, Q=0, T=1
    doOp(2'b11, 32'h5, 32'h3);
    check("R5 R6 sub no borrow", outs(), {3'b001, 32'h7});
    doOp(2'b01, '0, '0);
    // subtract with borrow: 2 - 3, Q=1 T=0
    doOp(2'b11, 32'h1, 32'h3);
    check("R7 borrow", outs(), {3'b100, 32'hFFFF_FFFF});
    // Q!=M -> add: 0xFFFFFFFE + 3 = 1, carry, Q=1^0^1=0, T=1
    doOp(2'b11, 32'hFFFF_FFFF, 32'h3);
    check("R5 R7 R8 add carry", outs(), {3'b001, 32'h1});
    // T=1 enters bit 0: (0x10<<1)|1 = 0x21, minus 1 = 0x20
    doOp(2'b11, 32'h10, 32'h1);
    check("R6 T into bit0", outs(), {3'b001, 32'h20});
  endtask

  task automatic tSigned();
    doOp(2'b10, 32'h8000_0000, 32'h1);
    check("R4 neg/pos", outs(), {3'b101, mRem});
    doOp(2'b10, 32'h1, 32'hFFFF_FFFF);
    check("R4 pos/neg", outs(), {3'b011, mRem});
    doOp(2'b10, 32'h7, 32'h3);
    check("R4 pos/pos", outs(), {3'b000, mRem});
    doOp(2'b10, 32'hF000_0000, 32'h8000_0001);
    check("R4 neg/neg", outs(), {3'b110, mRem});
  endtask

  task automatic tIdle();
    doOp(2'b11, 32'h1234_5678, 32'h0000_0F0F);
    check("R10 step visible next edge", outs(), exps());
    doOp(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R2 idle holds", outs(), exps());
    doOp(2'b01, 32'hAAAA_AAAA, 32'h5555_5555);
    check("R3 result kept", outs(), exps());
  endtask

  task automatic tZero();
    doOp(2'b01, '0, '0);
    doOp(2'b11, 32'h4000_0001, 32'h0);
    check("R9 zero divisor", outs(), {3'b001, 32'h8000_0002});
    doOp(2'b11, 32'h8000_0000, 32'h0);
    check("R9 zero divisor msb", outs(), {3'b100, 32'h0000_0001});
  endtask

  task automatic tSweep();
    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      logic [W-1:0] a, b;
      op = ($urandom_range(0, 9) < 7) ? 2'b11 : 2'($urandom_range(0, 2));
      a = $urandom;
      b = (i % 17 == 0) ? '0 : $urandom;
      doOp(op, a, b);
      check("R5 R6 R7 R8 sweep", outs(), exps());
    end
  endtask

  initial begin
    @(negedge clk);
    tReset();
    tHand();
    tSigned();
    tIdle();
    tZero();
    tSweep();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule